// File: doc/BRIEF.md
# Timer Capture-Compare Status Flags

This block is one channel of a general-purpose timer. It has a 16-bit up-counter that advances on each cycle in which the tick input is high. Four general registers sit beside the counter. Each of them works in one of two roles:

- **Compare role:** the register raises its flag when the counter reaches its value.
- **Capture role:** the register latches the counter value when a chosen edge appears on its capture pin, and raises its flag.

A fifth flag records a counter wrap-around.

Software clears a flag in two steps. It first reads the flag while it is 1, then writes 0 to it. A flag can also be dropped by hardware when a transfer engine, started by that flag's request line, acknowledges. Each flag drives a level request output, gated by its own enable bit. The register port is a plain address, strobe and data interface with a combinational read path.

Top module: `tmr_ccflags`

## Requirements
- R1: After reset the counter, the four general registers, the role register and the enable register are 0. The status register reads 0x00C0: bits 7 and 6 are fixed at 1 and bits 4..0 are the flags.
- R2: The counter sits at address 1. It increments by one at each clock edge where tick_i is high. A bus write to address 1 loads it instead, and the write takes priority over the tick.
- R3: Status bit 4 (wrap flag) sets when a tick moves the counter from 0xFFFF to 0x0000. Loading the counter by a bus write never sets it.
- R4: General register k (address 4+k, k=0..3) in compare role: status bit k sets at the clock edge at which a tick makes the counter equal to the register.
- R5: In capture role, register k copies the counter when the selected edge of cap_i[k] has passed a two-flop synchronizer, and status bit k sets. The opposite edge does nothing.
- R6: A 0 written to a status bit clears that flag only if a status read returned that flag as 1 since the last status write. Writing 1 never sets a flag.
- R7: A status read arms only the flags it returns as 1. Every status write, whatever its data, leaves all flags disarmed afterwards.
- R8: A one-cycle pulse on xfer_ack_i[k] clears flag k when xfer_keep_i[k] is 0, and has no effect when it is 1.
- R9: dma_ack_i clears flag 0 when dma_src_en_i is 1, and affects no other flag.
- R10: When a set condition and a clear condition hit the same flag in the same cycle, the flag ends up set.
- R11: irq_o[j] is status flag j ANDed with bit j of the enable register (address 3, bits 4..0).
- R12: The role register (address 2) holds bit k = 1 for capture role of register k and bit 4+k = 1 for falling-edge capture. Capture pins have no effect on a register in compare role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one count per high cycle |
| cap_i | input | 4 | Asynchronous capture pins, one per general register |
| addr_i | input | 3 | Register address |
| rd_en_i | input | 1 | Read strobe (arms flags when reading status) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| xfer_ack_i | input | 4 | Transfer-controller start acknowledge per flag 0..3 |
| xfer_keep_i | input | 4 | Per flag: 1 keeps the flag on acknowledge |
| dma_ack_i | input | 1 | DMA start acknowledge for flag 0 |
| dma_src_en_i | input | 1 | DMA source-enable; 1 lets dma_ack_i clear flag 0 |
| irq_o | output | 5 | Gated level requests: bits 3..0 registers, bit 4 wrap |

## Verification
The assertions take the transfer acknowledges to be single-cycle pulses. They also take capture pin levels to be held for more than the two synchronizer cycles, so every edge the flag logic sees is a clean one-cycle event. The bench holds each capture level for six cycles and pulses every acknowledge for exactly one cycle. It never raises read and write strobes in the same cycle. It stops the tick while it loads the counter, so each compare match and wrap falls on a tick it has placed on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NGR  = 4;
  localparam int NFLG = NGR + 1;
  localparam int AW   = 3;

  localparam logic [AW-1:0] ADR_STAT = 3'd0;
  localparam logic [AW-1:0] ADR_CNT  = 3'd1;
  localparam logic [AW-1:0] ADR_MODE = 3'd2;
  localparam logic [AW-1:0] ADR_IEN  = 3'd3;

  // true when the selected edge is seen between two synchronized samples
  function automatic logic edge_seen(input logic prev, input logic cur, input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         step_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] incr(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  assign step_o = tick_i & ~wr_i;
  assign nxt_o  = incr(cnt_q);
  assign wrap_o = step_o & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= incr(cnt_q);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> cnt_q == $past(cnt_q) + W'(1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> cnt_q == $past(wdata_i)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0); // R3
endmodule

// File: rtl/tmr_capsync.sv
module tmr_capsync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cap_i,
  input  logic [N-1:0] fall_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= cap_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign evt_o[i] = tmr_pkg::edge_seen(s3_q[i], s2_q[i], fall_i[i]);

    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[i] && $stable(fall_i[i]) |=> !evt_o[i]); // R5
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic aclr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic q_q, armed_q, wclr;

  assign wclr = wr_i & ~wbit_i & armed_q;
  assign q_o  = q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      q_q <= set_i | (q_q & ~(aclr_i | wclr));
      if (wr_i)            armed_q <= 1'b0;
      else if (rd_i && q_q) armed_q <= 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q); // R10
  AST_HOLD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    q_q && !aclr_i && !armed_q |=> q_q); // R6
  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !q_q && !set_i |=> !q_q); // R6
  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !armed_q); // R7
endmodule

// File: rtl/tmr_ccflags.sv
module tmr_ccflags #(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic [tmr_pkg::NGR-1:0]  cap_i,
  input  logic [tmr_pkg::AW-1:0]   addr_i,
  input  logic                     rd_en_i,
  input  logic                     wr_en_i,
  input  logic [CNT_W-1:0]         wdata_i,
  output logic [CNT_W-1:0]         rdata_o,
  input  logic [tmr_pkg::NGR-1:0]  xfer_ack_i,
  input  logic [tmr_pkg::NGR-1:0]  xfer_keep_i,
  input  logic                     dma_ack_i,
  input  logic                     dma_src_en_i,
  output logic [tmr_pkg::NFLG-1:0] irq_o
);
  import tmr_pkg::*;
  localparam int MW = 2 * NGR;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             step, wrap;
  logic [CNT_W-1:0] gr_q [NGR];
  logic [MW-1:0]    mode_q;
  logic [NFLG-1:0]  ien_q;
  logic [NGR-1:0]   cap_role, fall_sel, sync_evt, cap_evt, cmp_hit;
  logic [NFLG-1:0]  set_vec, aclr_vec, flag_q;
  logic             wr_stat, rd_stat, wr_cnt;
  logic             unused_wbits;

  assign cap_role = mode_q[NGR-1:0];
  assign fall_sel = mode_q[MW-1:NGR];
  assign wr_stat  = wr_en_i && addr_i == ADR_STAT;
  assign rd_stat  = rd_en_i && addr_i == ADR_STAT;
  assign wr_cnt   = wr_en_i && addr_i == ADR_CNT;
  assign unused_wbits = ^wdata_i[CNT_W-1:MW];

  tmr_counter #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_cnt), .wdata_i(wdata_i),
    .cnt_o(cnt), .nxt_o(cnt_nxt), .step_o(step), .wrap_o(wrap)
  );

  tmr_capsync #(.N(NGR)) sync_i (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .fall_i(fall_sel), .evt_o(sync_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_MODE) mode_q <= wdata_i[MW-1:0];
      if (addr_i == ADR_IEN)  ien_q  <= wdata_i[NFLG-1:0];
    end
  end

  for (genvar k = 0; k < NGR; k++) begin : g_gr
    logic wr_gr;
    assign wr_gr      = wr_en_i && addr_i[AW-1] && addr_i[AW-2:0] == (AW-1)'(k);
    assign cap_evt[k] = sync_evt[k] & cap_role[k];
    assign cmp_hit[k] = ~cap_role[k] & step & (cnt_nxt == gr_q[k]);
    assign set_vec[k] = cmp_hit[k] | cap_evt[k];
    if (k == 0) begin : g_dma
      assign aclr_vec[k] = (xfer_ack_i[k] & ~xfer_keep_i[k]) | (dma_ack_i & dma_src_en_i);
    end else begin : g_plain
      assign aclr_vec[k] = xfer_ack_i[k] & ~xfer_keep_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gr_q[k] <= '0;
      else if (cap_evt[k]) gr_q[k] <= cnt;
      else if (wr_gr)      gr_q[k] <= wdata_i;
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[k] |=> gr_q[k] == $past(cnt)); // R5
    AST_CMP_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[k] |=> cnt == gr_q[k]); // R4
  end

  assign set_vec[NGR]  = wrap;
  assign aclr_vec[NGR] = 1'b0;

  for (genvar j = 0; j < NFLG; j++) begin : g_flag
    tmr_flag flag_i (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec[j]), .aclr_i(aclr_vec[j]),
      .rd_i(rd_stat), .wr_i(wr_stat), .wbit_i(wdata_i[j]), .q_o(flag_q[j])
    );

    AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      aclr_vec[j] && !set_vec[j] |=> !flag_q[j]); // R8
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_q[j] |-> !irq_o[j]); // R11
  end

  assign irq_o = flag_q & ien_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_STAT: begin
        rdata_o[7:6]      = 2'b11;
        rdata_o[NFLG-1:0] = flag_q;
      end
      ADR_CNT:  rdata_o = cnt;
      ADR_MODE: rdata_o[MW-1:0] = mode_q;
      ADR_IEN:  rdata_o[NFLG-1:0] = ien_q;
      default:  rdata_o = gr_q[addr_i[AW-2:0]];
    endcase
  end
endmodule

// File: tb/tmr_ccflags_tb.sv
module tmr_ccflags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] cap = 4'h0;
  logic [2:0] addr = 3'd0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [3:0] xack = 4'h0, xkeep = 4'h0;
  logic dack = 1'b0, dsen = 1'b0;
  logic [4:0] irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_ccflags dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cap_i(cap), .addr_i(addr),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .xfer_ack_i(xack), .xfer_keep_i(xkeep), .dma_ack_i(dack),
    .dma_src_en_i(dsen), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_all();
    logic [15:0] d;
    rd(3'd0, d);
    wr(3'd0, 16'h0000);
  endtask

  // bring flag k up by a compare match: counter 0x0100, register k 0x0101
  task automatic set_flag(input int k);
    wr(3'd2, 16'h0000);
    for (int j = 0; j < 4; j++) wr(3'(4 + j), (j == k) ? 16'h0101 : 16'h0F00);
    wr(3'd1, 16'h0100);
    ticks(1);
  endtask

  task automatic pulse_x(input logic [3:0] a, input logic d);
    @(negedge clk); xack = a; dack = d;
    @(negedge clk); xack = 4'h0; dack = 1'b0;
  endtask

  initial begin
    logic [15:0] d, x;
    logic [15:0] bases [3];
    bases[0] = 16'h0010; bases[1] = 16'h8000; bases[2] = 16'hFFF0;
    waitn(3);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, d); chk("R1 status", d, 16'h00C0);
    rd(3'd1, d); chk("R1 counter", d, 16'h0000);
    rd(3'd2, d); chk("R1 role", d, 16'h0000);
    rd(3'd3, d); chk("R1 enable", d, 16'h0000);
    for (int k = 0; k < 4; k++) begin rd(3'(4 + k), d); chk("R1 gr", d, 16'h0000); end
    chk("R1 irq", {11'h0, irq}, 16'h0);

    // R2 counting and loading
    for (int s = 0; s < 4; s++) begin
      x = 16'h1234 + 16'(s * 16'h1111);
      wr(3'd1, x);
      rd(3'd1, d); chk("R2 load", d, x);
      ticks(3 + s);
      rd(3'd1, d); chk("R2 count", d, x + 16'(3 + s));
    end
    @(negedge clk); addr = 3'd1; wdata = 16'h0042; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(3'd1, d); chk("R2 write beats tick", d, 16'h0042);

    // R3 wrap flag
    for (int k = 0; k < 4; k++) wr(3'(4 + k), 16'h5555);
    clr_all();
    wr(3'd1, 16'hFFFE);
    ticks(1);
    rd(3'd0, d); chk("R3 before wrap", d, 16'h00C0);
    ticks(1);
    rd(3'd1, d); chk("R3 counter zero", d, 16'h0000);
    rd(3'd0, d); chk("R3 wrap flag", d, 16'h00D0);
    wr(3'd3, 16'h0010);
    @(negedge clk); chk("R11 wrap irq", {11'h0, irq}, 16'h0010);
    wr(3'd3, 16'h0000);
    clr_all();
    wr(3'd1, 16'hFFFF);
    wr(3'd1, 16'h0000);
    rd(3'd0, d); chk("R3 load no wrap", d, 16'h00C0);

    // R4 compare sweep over registers and bases
    wr(3'd2, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 3; b++) begin
        for (int j = 0; j < 4; j++) wr(3'(4 + j), (j == k) ? bases[b] + 16'd5 : bases[b] + 16'd100);
        wr(3'd1, bases[b]);
        clr_all();
        ticks(4);
        rd(3'd0, d); chk("R4 before match", d, 16'h00C0);
        ticks(1);
        rd(3'd0, d); chk("R4 match", d, 16'h00C0 | 16'(1 << k));
        clr_all();
      end
    end

    // R5 / R12 capture on both edges for every register
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 2; f++) begin
        wr(3'd2, 16'((1 << k) | (f << (4 + k))));
        @(negedge clk); cap[k] = f[0];
        waitn(6);
        clr_all();
        wr(3'(4 + k), 16'hAAAA);
        x = 16'h0300 + 16'(k * 16 + f);
        wr(3'd1, x);
        @(negedge clk); cap[k] = ~f[0];
        waitn(6);
        rd(3'(4 + k), d); chk("R5 captured value", d, x);
        rd(3'd0, d); chk("R5 capture flag", d, 16'h00C0 | 16'(1 << k));
        clr_all();
        wr(3'd1, x + 16'd7);
        @(negedge clk); cap[k] = f[0];
        waitn(6);
        rd(3'd0, d); chk("R5 wrong edge flag", d, 16'h00C0);
        rd(3'(4 + k), d); chk("R5 wrong edge value", d, x);
      end
    end
    wr(3'd2, 16'h0000);
    clr_all();
    wr(3'd4, 16'h1357);
    @(negedge clk); cap[0] = 1'b1; waitn(6);
    @(negedge clk); cap[0] = 1'b0; waitn(6);
    rd(3'd0, d); chk("R12 compare role ignores pin", d, 16'h00C0);
    rd(3'd4, d); chk("R12 compare role keeps value", d, 16'h1357);

    // R6 / R7 clearing handshake
    set_flag(1);
    wr(3'd0, 16'h00FF);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R6 write0 unarmed", d, 16'h00C2);
    wr(3'd0, 16'h00FF);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R7 write disarms", d, 16'h00C2);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R6 read then write0", d, 16'h00C0);
    wr(3'd0, 16'h001F);
    rd(3'd0, d); chk("R6 write1 no set", d, 16'h00C0);
    rd(3'd0, d);
    set_flag(2);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R7 read as 0 no arm", d, 16'h00C4);
    clr_all();

    // R8 transfer-controller clearing
    for (int k = 0; k < 4; k++) begin
      set_flag(k);
      xkeep = 4'hF;
      pulse_x(4'(1 << k), 1'b0);
      rd(3'd0, d); chk("R8 keep", d, 16'h00C0 | 16'(1 << k));
      xkeep = 4'h0;
      pulse_x(4'(1 << k), 1'b0);
      rd(3'd0, d); chk("R8 clear", d, 16'h00C0);
      wr(3'd0, 16'h00FF);
    end

    // R9 DMA clearing, flag 0 only
    set_flag(0);
    dsen = 1'b0; pulse_x(4'h0, 1'b1);
    rd(3'd0, d); chk("R9 dma disabled", d, 16'h00C1);
    dsen = 1'b1; pulse_x(4'h0, 1'b1);
    rd(3'd0, d); chk("R9 dma clear", d, 16'h00C0);
    set_flag(3);
    pulse_x(4'h0, 1'b1);
    rd(3'd0, d); chk("R9 dma other flag", d, 16'h00C8);
    dsen = 1'b0;
    clr_all();

    // R10 set wins over same-cycle clear
    set_flag(0);
    wr(3'd1, 16'h0100);
    @(negedge clk); tick = 1'b1; xack = 4'h1;
    @(negedge clk); tick = 1'b0; xack = 4'h0;
    rd(3'd0, d); chk("R10 set wins", d, 16'h00C1);

    // R11 interrupt gating
    wr(3'd3, 16'h0001);
    @(negedge clk); chk("R11 irq enabled", {11'h0, irq}, 16'h0001);
    wr(3'd3, 16'h001E);
    @(negedge clk); chk("R11 irq masked", {11'h0, irq}, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule